// File: doc/BRIEF.md
# Receive Buffer Completion, Overrun and Interrupt Flags

This block keeps three per-buffer bit vectors for a message controller with a parameterised number of receive buffers (16 by default). The vectors are a completion flag, an overrun flag and an interrupt enable. The receive path pulses one strobe per buffer when it has finished writing a message into that buffer. The block marks that buffer as complete. If the buffer was already marked complete before this message arrived, the block also marks it as overrun. Software sees all three vectors through a byte-wide register port and acknowledges flags by writing zeros.

The two flag vectors only accept writes of 0. Writing 1 to a flag bit leaves it as it is. When the hardware sets a flag bit in the same cycle that software clears it, the bit ends up set. A read that is flagged as the first half of a read-modify-write returns all ones for the overrun bytes, so writing that value back changes nothing. A single interrupt request is raised, one cycle later, whenever any buffer is both complete and enabled.

Top module: `rxflag_regs`

## Requirements
- R1: After reset every completion, overrun and enable bit is 0, and `rx_irq_o` is 0.
- R2: A pulse on `store_i[x]` makes completion bit x read 1 from the next cycle on. Writing 0 to that bit clears it, and writing 1 leaves it unchanged.
- R3: Overrun bit x becomes 1 after a store into buffer x only when completion bit x was already 1 before that store. The first store into a buffer whose completion bit is 0 leaves overrun bit x at 0.
- R4: Writing 0 to an overrun bit clears it, and writing 1 leaves it unchanged.
- R5: If a hardware set and a software write-0 hit the same completion or overrun bit in the same cycle, the bit ends up 1.
- R6: A read of an overrun byte with `cpu_rmw`=1 returns 0xFF. The same read with `cpu_rmw`=0 returns the stored bits.
- R7: `rx_irq_o` equals, one cycle later, the OR over all buffers of (completion AND enable).
- R8: Changing an enable bit gates or ungates an already-set completion flag at `rx_irq_o` on the cycle after the write.
- R9: Byte map, where bit 0 of each byte is the lowest buffer in that byte. Completion is at 0x4A (buffers 7:0) and 0x4B (buffers 15:8). Overrun is at 0x4C and 0x4D. Enable is at 0x4E and 0x4F. Other offsets read 0 and ignore writes. `cpu_rdata` is 0 whenever `cpu_rd` is 0, and otherwise it is valid in the same cycle.
- R10: Enable bits are plain read/write storage. A write stores `cpu_wdata` exactly, and a read returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| store_i | input | NUM_BUF | One-cycle strobe per buffer: message stored |
| cpu_addr | input | ADDR_W | Byte offset of the access |
| cpu_we | input | 1 | Byte write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_rmw | input | 1 | Read belongs to a read-modify-write |
| cpu_rdata | output | 8 | Read data, combinational |
| rx_irq_o | output | 1 | Combined reception interrupt request |

## Verification
Directed patterns come first. Repeated stores into one buffer separate a correct overrun rule from one that flags every store. A store in the same cycle as a write-0 to the same bit shows which side has priority. Writes of all ones show whether the flags are wrongly treated as write-1-to-set. Enable toggles over a pending flag expose a missing mask or a wrong interrupt latency. Plain and read-modify-write reads of the same byte separate the two read paths. A random phase then mixes stores to many buffers with writes and reads over the mapped and unmapped offsets around the map, and compares the design with the model on every cycle.

// File: rtl/rxflag_pkg.sv
`timescale 1ns/1ps
package rxflag_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      REG_COMP = 2'd0,
      REG_OVR  = 2'd1,
      REG_IEN  = 2'd2,
      REG_NONE = 2'd3
   } rxflag_reg_e;

   // true when two byte windows of length n share an offset
   function automatic bit windows_overlap(input int a, input int b, input int n);
      return (a < b + n) && (b < a + n);
   endfunction
endpackage

// File: rtl/rxflag_flag_bank.sv
`timescale 1ns/1ps
module rxflag_flag_bank #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] flags_o
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        q <= 1'b0;
         else if (set_i[i]) q <= 1'b1;   // hardware set has priority
         else if (clr_i[i]) q <= 1'b0;
      end
      assign flags_o[i] = q;
   end
endmodule

// File: rtl/rxflag_enable_reg.sv
`timescale 1ns/1ps
module rxflag_enable_reg #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] mask_i,
   input  logic [W-1:0] val_i,
   output logic [W-1:0] en_o
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         q <= 1'b0;
         else if (mask_i[i]) q <= val_i[i];
      end
      assign en_o[i] = q;
   end
endmodule

// File: rtl/rxflag_irq_combine.sv
`timescale 1ns/1ps
module rxflag_irq_combine #(
   parameter int W          = 16,
   parameter bit REGISTERED = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] comp_i,
   input  logic [W-1:0] en_i,
   output logic         irq_o
);
   logic pend;
   assign pend = |(comp_i & en_i);

   if (REGISTERED) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= pend;
      end
      assign irq_o = irq_q;
   end else begin : g_comb
      assign irq_o = pend;
   end
endmodule

// File: rtl/rxflag_cpu_port.sv
`timescale 1ns/1ps
module rxflag_cpu_port
   import rxflag_pkg::*;
#(
   parameter int NUM_BUF   = 16,
   parameter int ADDR_W    = 8,
   parameter int COMP_BASE = 'h4A,
   parameter int OVR_BASE  = 'h4C,
   parameter int IEN_BASE  = 'h4E
) (
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic               we_i,
   input  logic [BYTE_W-1:0]  wdata_i,
   input  logic               rd_i,
   input  logic               rmw_i,
   input  logic [NUM_BUF-1:0] comp_i,
   input  logic [NUM_BUF-1:0] ovr_i,
   input  logic [NUM_BUF-1:0] ien_i,
   output logic [NUM_BUF-1:0] comp_clr_o,
   output logic [NUM_BUF-1:0] ovr_clr_o,
   output logic [NUM_BUF-1:0] ien_mask_o,
   output logic [NUM_BUF-1:0] ien_val_o,
   output logic [BYTE_W-1:0]  rdata_o
);
   localparam int NBYTES = NUM_BUF / BYTE_W;
   localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

   rxflag_reg_e      region;
   logic [IDX_W-1:0] bidx;

   always_comb begin
      region = REG_NONE;
      bidx   = '0;
      for (int b = 0; b < NBYTES; b++) begin
         if (addr_i == ADDR_W'(COMP_BASE + b)) begin
            region = REG_COMP;
            bidx   = IDX_W'(b);
         end
         if (addr_i == ADDR_W'(OVR_BASE + b)) begin
            region = REG_OVR;
            bidx   = IDX_W'(b);
         end
         if (addr_i == ADDR_W'(IEN_BASE + b)) begin
            region = REG_IEN;
            bidx   = IDX_W'(b);
         end
      end
   end

   always_comb begin
      comp_clr_o = '0;
      ovr_clr_o  = '0;
      ien_mask_o = '0;
      if (we_i) begin
         case (region)
            REG_COMP: comp_clr_o[bidx*BYTE_W +: BYTE_W] = ~wdata_i;
            REG_OVR:  ovr_clr_o[bidx*BYTE_W +: BYTE_W]  = ~wdata_i;
            REG_IEN:  ien_mask_o[bidx*BYTE_W +: BYTE_W] = '1;
            default:  ;
         endcase
      end
   end

   assign ien_val_o = {NBYTES{wdata_i}};

   always_comb begin
      rdata_o = '0;
      if (rd_i) begin
         case (region)
            REG_COMP: rdata_o = comp_i[bidx*BYTE_W +: BYTE_W];
            REG_OVR:  rdata_o = rmw_i ? '1 : ovr_i[bidx*BYTE_W +: BYTE_W];
            REG_IEN:  rdata_o = ien_i[bidx*BYTE_W +: BYTE_W];
            default:  rdata_o = '0;
         endcase
      end
   end
endmodule

// File: rtl/rxflag_regs.sv
`timescale 1ns/1ps
module rxflag_regs
   import rxflag_pkg::*;
#(
   parameter int NUM_BUF   = 16,
   parameter int ADDR_W    = 8,
   parameter int COMP_BASE = 'h4A,
   parameter int OVR_BASE  = 'h4C,
   parameter int IEN_BASE  = 'h4E,
   parameter bit IRQ_REG   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_BUF-1:0] store_i,
   input  logic [ADDR_W-1:0]  cpu_addr,
   input  logic               cpu_we,
   input  logic [7:0]         cpu_wdata,
   input  logic               cpu_rd,
   input  logic               cpu_rmw,
   output logic [7:0]         cpu_rdata,
   output logic               rx_irq_o
);
   localparam int NBYTES = NUM_BUF / BYTE_W;
   localparam int ASPAN  = 2 ** ADDR_W;

   if ((NUM_BUF % BYTE_W) != 0 || NUM_BUF < BYTE_W) begin : g_bad_width
      $error("rxflag_regs: NUM_BUF must be a nonzero multiple of 8");
   end
   if (windows_overlap(COMP_BASE, OVR_BASE, NBYTES) ||
       windows_overlap(COMP_BASE, IEN_BASE, NBYTES) ||
       windows_overlap(OVR_BASE, IEN_BASE, NBYTES)) begin : g_bad_map
      $error("rxflag_regs: register windows overlap");
   end
   if (COMP_BASE + NBYTES > ASPAN || OVR_BASE + NBYTES > ASPAN ||
       IEN_BASE + NBYTES > ASPAN) begin : g_bad_addr
      $error("rxflag_regs: register window outside address range");
   end

   logic [NUM_BUF-1:0] comp_q, ovr_q, ien_q;
   logic [NUM_BUF-1:0] comp_clr, ovr_clr, ien_mask, ien_val;
   logic [NUM_BUF-1:0] ovr_set;

   // overrun uses the completion state held before this store
   assign ovr_set = store_i & comp_q;

   rxflag_cpu_port #(
      .NUM_BUF(NUM_BUF), .ADDR_W(ADDR_W),
      .COMP_BASE(COMP_BASE), .OVR_BASE(OVR_BASE), .IEN_BASE(IEN_BASE)
   ) u_port (
      .addr_i(cpu_addr), .we_i(cpu_we), .wdata_i(cpu_wdata),
      .rd_i(cpu_rd), .rmw_i(cpu_rmw),
      .comp_i(comp_q), .ovr_i(ovr_q), .ien_i(ien_q),
      .comp_clr_o(comp_clr), .ovr_clr_o(ovr_clr),
      .ien_mask_o(ien_mask), .ien_val_o(ien_val),
      .rdata_o(cpu_rdata)
   );

   rxflag_flag_bank #(.W(NUM_BUF)) u_comp (
      .clk(clk), .rst_n(rst_n), .set_i(store_i), .clr_i(comp_clr), .flags_o(comp_q)
   );

   rxflag_flag_bank #(.W(NUM_BUF)) u_ovr (
      .clk(clk), .rst_n(rst_n), .set_i(ovr_set), .clr_i(ovr_clr), .flags_o(ovr_q)
   );

   rxflag_enable_reg #(.W(NUM_BUF)) u_ien (
      .clk(clk), .rst_n(rst_n), .mask_i(ien_mask), .val_i(ien_val), .en_o(ien_q)
   );

   rxflag_irq_combine #(.W(NUM_BUF), .REGISTERED(IRQ_REG)) u_irq (
      .clk(clk), .rst_n(rst_n), .comp_i(comp_q), .en_i(ien_q), .irq_o(rx_irq_o)
   );
endmodule

// File: rtl/rxflag_chk.sv
`timescale 1ns/1ps
module rxflag_chk #(
   parameter int NUM_BUF  = 16,
   parameter int ADDR_W   = 8,
   parameter int OVR_BASE = 'h4C
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_BUF-1:0] store_i,
   input logic [ADDR_W-1:0]  cpu_addr,
   input logic               cpu_we,
   input logic [7:0]         cpu_wdata,
   input logic               cpu_rd,
   input logic               cpu_rmw,
   input logic [7:0]         cpu_rdata,
   input logic [NUM_BUF-1:0] comp,
   input logic [NUM_BUF-1:0] ovr
);
   localparam int NBYTES = NUM_BUF / 8;

   logic ovr_hit;
   assign ovr_hit = (int'(cpu_addr) >= OVR_BASE) && (int'(cpu_addr) < OVR_BASE + NBYTES);

   AST_STORE_MARKS_COMP: assert property (@(posedge clk) disable iff (!rst_n)
      (|store_i) |=> ((comp & $past(store_i)) == $past(store_i))); // R2

   AST_OVR_ONLY_ON_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((ovr & ~$past(ovr)) & ~($past(store_i) & $past(comp))) == '0)); // R3

   AST_OVR_WRITE_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_we && ovr_hit && cpu_wdata == 8'hFF) |=> (($past(ovr) & ~ovr) == '0)); // R4

   AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (|(store_i & comp)) |=> ((ovr & $past(store_i & comp)) == $past(store_i & comp))); // R5

   AST_RMW_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && cpu_rmw && ovr_hit) |-> (cpu_rdata == 8'hFF)); // R6

   AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_rd) |-> (cpu_rdata == 8'h00)); // R9
endmodule

bind rxflag_regs rxflag_chk #(
   .NUM_BUF(NUM_BUF), .ADDR_W(ADDR_W), .OVR_BASE(OVR_BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .store_i(store_i), .cpu_addr(cpu_addr),
   .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_rmw(cpu_rmw),
   .cpu_rdata(cpu_rdata), .comp(comp_q), .ovr(ovr_q)
);

// File: tb/tb_rxflag_regs.sv
`timescale 1ns/1ps
module tb_rxflag_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] store_i = '0;
   logic [7:0]  cpu_addr = '0;
   logic        cpu_we = 1'b0;
   logic [7:0]  cpu_wdata = '0;
   logic        cpu_rd = 1'b0;
   logic        cpu_rmw = 1'b0;
   logic [7:0]  cpu_rdata;
   logic        rx_irq_o;

   int    vectors = 0;
   int    fails = 0;
   string cur_tag = "R1";

   always #2.5 clk = ~clk;   // 200 MHz

   rxflag_regs dut (
      .clk(clk), .rst_n(rst_n), .store_i(store_i), .cpu_addr(cpu_addr),
      .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_rmw(cpu_rmw),
      .cpu_rdata(cpu_rdata), .rx_irq_o(rx_irq_o)
   );

   // reference model, bit-level and behavioural
   bit [15:0] m_comp, m_ovr, m_ien;
   bit        m_irq;

   always @(posedge clk) begin : model
      bit [15:0] nc, no, ni;
      bit        wb;
      bit        any;
      if (!rst_n) begin
         m_comp <= '0; m_ovr <= '0; m_ien <= '0; m_irq <= 1'b0;
      end else begin
         nc = m_comp; no = m_ovr; ni = m_ien; any = 1'b0;
         for (int i = 0; i < 16; i++) begin
            wb = cpu_wdata[i % 8];
            if (cpu_we && cpu_addr == 8'(8'h4A + i / 8) && !wb) nc[i] = 1'b0;
            if (cpu_we && cpu_addr == 8'(8'h4C + i / 8) && !wb) no[i] = 1'b0;
            if (cpu_we && cpu_addr == 8'(8'h4E + i / 8))        ni[i] = wb;
            if (store_i[i]) begin
               if (m_comp[i]) no[i] = 1'b1;
               nc[i] = 1'b1;
            end
            if (m_comp[i] && m_ien[i]) any = 1'b1;
         end
         m_comp <= nc; m_ovr <= no; m_ien <= ni; m_irq <= any;
      end
   end

   function automatic bit [7:0] exp_rd();
      if (!cpu_rd) return 8'h00;
      case (cpu_addr)
         8'h4A: return m_comp[7:0];
         8'h4B: return m_comp[15:8];
         8'h4C: return cpu_rmw ? 8'hFF : m_ovr[7:0];
         8'h4D: return cpu_rmw ? 8'hFF : m_ovr[15:8];
         8'h4E: return m_ien[7:0];
         8'h4F: return m_ien[15:8];
         default: return 8'h00;
      endcase
   endfunction

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         vectors++;
         if (rx_irq_o !== m_irq) begin
            fails++;
            $display("FAIL R7 irq: actual %b expected %b at %0t", rx_irq_o, m_irq, $time);
         end
         vectors++;
         if (cpu_rdata !== exp_rd()) begin
            fails++;
            $display("FAIL %s rdata @%h: actual %h expected %h at %0t",
                     cur_tag, cpu_addr, cpu_rdata, exp_rd(), $time);
         end
      end
   end

   task automatic cyc(input logic [15:0] st, input logic we, input logic [7:0] a,
                      input logic [7:0] wd, input logic rd, input logic rmw);
      store_i = st; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_rd = rd; cpu_rmw = rmw;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) cyc('0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0);
   endtask

   task automatic rd(input logic [7:0] a, input logic rmw);
      cyc('0, 1'b0, a, 8'h00, 1'b1, rmw);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   endtask

   initial begin
      #(5.0 * 100000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state of all six bytes
      cur_tag = "R1";
      for (int a = 8'h4A; a <= 8'h4F; a++) rd(8'(a), 1'b0);
      // R2: first store marks completion; R3: no overrun yet
      cur_tag = "R2";
      cyc(16'h0008, 0, 0, 0, 0, 0);
      rd(8'h4A, 0);
      cur_tag = "R3";
      rd(8'h4C, 0);
      cyc(16'h0008, 0, 0, 0, 0, 0);
      rd(8'h4C, 0);
      // R2: write 1 keeps, write 0 clears completion
      cur_tag = "R2";
      cyc('0, 1, 8'h4A, 8'hFF, 0, 0); rd(8'h4A, 0);
      // R8: enable over a pending flag, then disable
      cur_tag = "R8";
      cyc('0, 1, 8'h4E, 8'h08, 0, 0); idle(2);
      cyc('0, 1, 8'h4E, 8'h00, 0, 0); idle(2);
      cur_tag = "R2";
      cyc('0, 1, 8'h4A, 8'hF7, 0, 0); rd(8'h4A, 0);
      // R4: write ones keeps overrun, write 0 clears it
      cur_tag = "R4";
      cyc('0, 1, 8'h4C, 8'hFF, 0, 0); rd(8'h4C, 0);
      cyc('0, 1, 8'h4C, 8'hF7, 0, 0); rd(8'h4C, 0);
      // R5: store wins over simultaneous clears, high byte
      cur_tag = "R5";
      cyc(16'h0400, 0, 0, 0, 0, 0);
      cyc(16'h0400, 1, 8'h4B, 8'h00, 0, 0); rd(8'h4B, 0);
      cyc(16'h0400, 1, 8'h4D, 8'h00, 0, 0); rd(8'h4D, 0);
      // R6: read-modify-write read returns ones, plain read the flags
      cur_tag = "R6";
      rd(8'h4D, 1); rd(8'h4D, 0); rd(8'h4C, 1);
      // R10: enable storage exact
      cur_tag = "R10";
      cyc('0, 1, 8'h4F, 8'hA5, 0, 0); rd(8'h4F, 0);
      cyc('0, 1, 8'h4E, 8'h3C, 0, 0); rd(8'h4E, 0);
      // R7: irq from high-byte buffer 10 enabled
      cur_tag = "R7";
      cyc('0, 1, 8'h4F, 8'h04, 0, 0); idle(3);
      // R9: unmapped offsets read 0, writes ignored
      cur_tag = "R9";
      cyc('0, 1, 8'h49, 8'h00, 0, 0); cyc('0, 1, 8'h50, 8'hFF, 0, 0);
      rd(8'h49, 0); rd(8'h50, 0); rd(8'h4B, 0); rd(8'h4D, 0);
      // random mix
      for (int k = 0; k < 600; k++) begin
         logic [15:0] st;
         st = ($urandom_range(0, 3) == 0) ? 16'($urandom) & 16'($urandom) : '0;
         cyc(st, 1'($urandom_range(0, 2) == 0), 8'($urandom_range(8'h48, 8'h51)),
             8'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0));
      end
      idle(3);
      summary();
   end
endmodule